// File: doc/BRIEF.md
# Modem Line Status Change Detector

This block watches the four active-low modem handshake inputs of a serial port: clear-to-send, data-set-ready, ring indicator and carrier detect. Each pin is brought into the system clock domain through a two-flop synchroniser. The block then presents a 9-bit status word. That word holds the asserted level of each line as the complement of its pin, plus one sticky change flag per line and the current hardware flow-control mode bit.

The flags for carrier detect, data-set-ready and clear-to-send latch on any transition of their line. The ring flag latches only when a ring burst finishes, which is when the pin returns high. While any flag is set, an interrupt output stays high. The register bus shows a read of the status word to the block as a one-cycle strobe. The word shown during that strobe is the value returned, and the flags clear at the end of that cycle. A transition detected in that same cycle wins over the clear.

Top module: `modem_stat_mon`

## Requirements
- R1: Status bits 7, 6, 5 and 4 show the complement of the carrier-detect, ring, data-set-ready and clear-to-send pins. They follow a pin change after two clock edges of synchronisation.
- R2: Bit 3 (carrier detect), bit 1 (data-set-ready) and bit 0 (clear-to-send) are set by any transition of their pin, in either direction. The flag appears one edge after the level bit changes.
- R3: Bit 2 is set only when the ring pin goes from low to high, which ends a ring burst. A high-to-low transition of the ring pin leaves bit 2 at 0.
- R4: The interrupt output is high exactly when at least one of bits 3 to 0 is 1.
- R5: A one-cycle read strobe returns the status word shown in that cycle and clears bits 3 to 0 at the following edge.
- R6: A line transition detected in the same cycle as the read strobe leaves its flag set after the read. Other flags are cleared by that read.
- R7: Once set, a change flag stays set through any later pin activity until a read. This holds even if the line returns to its former level.
- R8: Bit 8 shows the flow-control mode input, registered once.
- R9: While reset is high, bits 8 and 3 to 0 are 0 and the synchroniser and history registers load the pin values. Lines that are active or inactive through reset therefore raise no flag after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| flow_mode_en | input | 1 | Hardware flow-control mode selected |
| rd_stb | input | 1 | One-cycle read strobe for the status word |
| stat_q | output | 9 | Status word: flow mode, levels, change flags |
| irq | output | 1 | Modem status interrupt |

## Verification
A read and a freshly detected line change can fall in the same cycle. The read tries to clear the flag while the edge detector tries to set it. The bench provokes this by first leaving the clear-to-send flag set. It then changes the data-set-ready pin and times the read strobe to the exact cycle in which the synchronised change reaches the edge detector. After that read, the data-set-ready flag must still be set, the clear-to-send flag must be clear, and the interrupt must stay high.

// File: rtl/msm_pkg.sv
package msm_pkg;

    localparam int LINE_CNT = 4;

    // Line index; also the position inside the level and delta fields.
    typedef enum logic [1:0] {
        LN_CTS = 2'd0,
        LN_DSR = 2'd1,
        LN_RI  = 2'd2,
        LN_DCD = 2'd3
    } line_e;

    typedef enum logic {
        DET_ANY   = 1'b0,
        DET_TRAIL = 1'b1
    } det_e;

    // 9-bit status word: [8] flow, [7:4] levels, [3:0] deltas.
    typedef struct packed {
        logic                flow;
        logic [LINE_CNT-1:0] level;
        logic [LINE_CNT-1:0] delta;
    } stat_t;

    localparam int STAT_W = $bits(stat_t);

    function automatic det_e det_for(input int idx);
        return (idx == int'(LN_RI)) ? DET_TRAIL : DET_ANY;
    endfunction

endpackage

// File: rtl/msm_sync.sv
module msm_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= din;
        end else begin
            pipe[0] <= din;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/msm_edge.sv
module msm_edge
    import msm_pkg::*;
#(
    parameter int WIDTH = LINE_CNT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_s,
    output logic [WIDTH-1:0] hit
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        prev_q <= pin_s;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        if (det_for(i) == DET_TRAIL) begin : g_trail
            // pin back high: active period ended
            assign hit[i] = ~rst & ~prev_q[i] & pin_s[i];
        end else begin : g_any
            assign hit[i] = ~rst & (prev_q[i] ^ pin_s[i]);
        end
    end
endmodule

// File: rtl/msm_flags.sv
module msm_flags #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] hit,
    input  logic             clr,
    output logic [WIDTH-1:0] flags
);
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~{WIDTH{clr}}) | hit;
    end
endmodule

// File: rtl/modem_stat_mon.sv
module modem_stat_mon
    import msm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              ri_n,
    input  logic              dcd_n,
    input  logic              flow_mode_en,
    input  logic              rd_stb,
    output logic [STAT_W-1:0] stat_q,
    output logic              irq
);
    logic [LINE_CNT-1:0] pins_raw;
    logic [LINE_CNT-1:0] pins_s;
    logic [LINE_CNT-1:0] edge_hit;
    logic [LINE_CNT-1:0] flags;
    logic                flow_q;
    stat_t               stat;

    always_comb begin
        pins_raw         = '0;
        pins_raw[LN_CTS] = cts_n;
        pins_raw[LN_DSR] = dsr_n;
        pins_raw[LN_RI]  = ri_n;
        pins_raw[LN_DCD] = dcd_n;
    end

    msm_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINE_CNT)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (pins_raw),
        .dout(pins_s)
    );

    msm_edge #(.WIDTH(LINE_CNT)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .pin_s(pins_s),
        .hit  (edge_hit)
    );

    msm_flags #(.WIDTH(LINE_CNT)) u_flags (
        .clk  (clk),
        .rst  (rst),
        .hit  (edge_hit),
        .clr  (rd_stb),
        .flags(flags)
    );

    always_ff @(posedge clk) begin
        if (rst) flow_q <= 1'b0;
        else     flow_q <= flow_mode_en;
    end

    always_comb begin
        stat.flow  = flow_q;
        stat.level = ~pins_s;
        stat.delta = flags;
    end

    assign stat_q = stat;
    assign irq    = |flags;
endmodule

// File: rtl/msm_chk.sv
module msm_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       cts_n,
    input logic       dsr_n,
    input logic       ri_n,
    input logic       dcd_n,
    input logic       flow_mode_en,
    input logic       rd_stb,
    input logic [8:0] stat_q,
    input logic       irq
);
    // sticky: without a read no flag drops (R7)
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> ((stat_q[3:0] & $past(stat_q[3:0])) == $past(stat_q[3:0])));

    // read with no fresh change empties the flags (R5)
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && $stable(stat_q[7:4])) |=> (stat_q[3:0] == 4'd0));

    // ring flag only after active level ended (R3)
    p_ring_trail_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q[2]) |-> (!$past(stat_q[6]) && $past(stat_q[6], 2)));

    // flow bit registered once (R8)
    p_flow_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (stat_q[8] == $past(flow_mode_en)));

    // interrupt rises only together with a flag (R4)
    p_irq_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $rose(stat_q[3:0] != 4'd0));

    if (SYNC_STAGES == 2) begin : g_lvl
        // levels follow pins after two edges (R1)
        p_level_r1: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(rst, 2)) |->
            (stat_q[7:4] == ~$past({dcd_n, ri_n, dsr_n, cts_n}, 2)));
    end
endmodule

bind modem_stat_mon msm_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cts_n       (cts_n),
    .dsr_n       (dsr_n),
    .ri_n        (ri_n),
    .dcd_n       (dcd_n),
    .flow_mode_en(flow_mode_en),
    .rd_stb      (rd_stb),
    .stat_q      (stat_q),
    .irq         (irq)
);

// File: tb/modem_stat_mon_test.sv
module modem_stat_mon_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cts_n = 1'b0, dsr_n = 1'b0, ri_n = 1'b0, dcd_n = 1'b0;
    logic       flow_mode_en = 1'b1;
    logic       rd_stb = 1'b0;
    logic [8:0] stat_q;
    logic       irq;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    modem_stat_mon uut (
        .clk(clk), .rst(rst),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
        .flow_mode_en(flow_mode_en), .rd_stb(rd_stb),
        .stat_q(stat_q), .irq(irq)
    );

    // pins {dcd_n, ri_n, dsr_n, cts_n}, expected status after settling
    localparam int NVEC = 8;
    localparam logic [12:0] VEC [NVEC] = '{
        {4'b1110, 9'h011},  // R2 cts active -> dcts
        {4'b1100, 9'h032},  // R2 dsr active -> ddsr
        {4'b1000, 9'h070},  // R3 ring starts, no flag
        {4'b1100, 9'h034},  // R3 ring ends -> trailing flag
        {4'b0100, 9'h0B8},  // R2 dcd active -> ddcd
        {4'b1011, 9'h04B},  // R2 three lines toggle, ring starts
        {4'b1111, 9'h004},  // R3 ring ends
        {4'b1111, 9'h000}   // R1 no change, no flag
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic set_pins(input logic [3:0] p);
        {dcd_n, ri_n, dsr_n, cts_n} = p;
    endtask

    task automatic do_read();
        @(negedge clk) rd_stb = 1'b1;
        @(negedge clk) rd_stb = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // reset with every line active and flow mode requested
        repeat (4) @(negedge clk);
        chk("R9 reset flow/flags", {23'd0, stat_q[8], 4'd0, stat_q[3:0]}, 32'h0);
        chk("R9 reset irq", {31'd0, irq}, 32'd0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 no spurious flag, R8 flow, R1 levels", {23'd0, stat_q}, 32'h1F0);
        chk("R9 irq quiet", {31'd0, irq}, 32'd0);

        // R8: flow bit follows after one edge
        flow_mode_en = 1'b0;
        @(negedge clk);
        chk("R8 flow off", {31'd0, stat_q[8]}, 32'd0);

        // go idle and clear
        set_pins(4'b1111);
        settle();
        do_read();
        chk("R5 cleared after idle", {23'd0, stat_q}, 32'h000);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            set_pins(VEC[i][12:9]);
            settle();
            chk("R1/R2/R3 status vector", {23'd0, stat_q}, {23'd0, VEC[i][8:0]});
            chk("R4 irq vs flags", {31'd0, irq}, {31'd0, (VEC[i][3:0] != 4'd0)});
            do_read();
            chk("R5 flags cleared by read", {28'd0, stat_q[3:0]}, 32'd0);
        end

        // R7: cts pulses and returns; flag holds until read
        set_pins(4'b1110);
        repeat (3) @(negedge clk);
        set_pins(4'b1111);
        settle();
        repeat (10) @(negedge clk);
        chk("R7 sticky after pulse", {23'd0, stat_q}, 32'h001);
        chk("R7 irq held", {31'd0, irq}, 32'd1);
        do_read();
        chk("R7 cleared by read", {23'd0, stat_q}, 32'h000);
        chk("R4 irq low after read", {31'd0, irq}, 32'd0);

        // R6: dsr edge reaches detector in the read cycle
        set_pins(4'b1110);
        settle();
        chk("R6 setup dcts", {23'd0, stat_q}, 32'h011);
        set_pins(4'b1100);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk) rd_stb = 1'b1;
        @(negedge clk) rd_stb = 1'b0;
        chk("R6 edge wins over read", {28'd0, stat_q[3:0]}, 32'h2);
        chk("R6 levels", {28'd0, stat_q[7:4]}, 32'h3);
        chk("R6 irq stays", {31'd0, irq}, 32'd1);
        do_read();
        chk("R5 final clear", {28'd0, stat_q[3:0]}, 32'd0);

        // R8: flow on again
        flow_mode_en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 flow on", {31'd0, stat_q[8]}, 32'd1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule